// File: doc/BRIEF.md
# Operand Addressing Unit

This unit resolves one 6-bit operand specifier of a register-based 16-bit instruction. It uses the same path for source and destination specifiers. It holds a file of eight 16-bit general registers. Register 7 serves as the instruction pointer. The unit reads extension words and operands through a synchronous memory read port with a request/ready handshake. When a specifier has been resolved, the unit returns the operand value and the effective address with a one-cycle done strobe. It also applies any register side effect, such as predecrement, postincrement or advancing the instruction pointer.

The execution stage writes results back through a small register write port. It can observe any register through a read port. Every mode works with every register, including the instruction pointer.

Top module: `opu_top`

## Requirements
- R1: After reset all eight registers read 0, and busy_o, done_o and mem_req_o are 0.
- R2: spec_i bits 5:3 select the mode and bits 2:0 select the register. Mode 0 (and the reserved mode 7) is register-direct. done_o rises one cycle after the accepting edge, with operand_o equal to the register, ea_o = 0 and is_reg_o = 1. No memory access is made.
- R3: Mode 1 (indirect) reads memory at the register value. That value becomes ea_o, and the register is unchanged.
- R4: Mode 2 (postincrement) reads at the register value, and the register reads that value plus 2 when done_o is high.
- R5: Mode 3 (predecrement) subtracts 2 from the register and reads at the new value. The register holds the new value when done_o is high.
- R6: Mode 4 (offset) first fetches a word at register 7. The effective address is that word plus the named register's value after register 7 has advanced by 2.
- R7: Mode 5 (immediate) fetches the operand at register 7. ea_o is the fetch address, and register 7 advances by 2.
- R8: Mode 6 (absolute) fetches an address word at register 7, then reads the operand at that address. Register 7 advances by 2.
- R9: mem_req_o stays high with a stable mem_addr_o until mem_ready_i is seen. Each access takes one cycle plus its wait cycles, and done_o rises one cycle after the last ready.
- R10: start_i is ignored while busy_o is high. The result in progress and later outputs are unaffected.
- R11: The register write port takes effect when the unit is idle and is ignored while busy_o is high.
- R12: Every mode behaves as specified with every register 0 to 7, including register 7 in postincrement and predecrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin resolving spec_i (accepted when idle) |
| spec_i | input | 6 | Operand specifier: mode[5:3], register[2:0] |
| busy_o | output | 1 | A resolution is in progress |
| done_o | output | 1 | One-cycle result strobe |
| is_reg_o | output | 1 | Operand is the register itself |
| operand_o | output | 16 | Resolved operand value |
| ea_o | output | 16 | Effective address (0 in register modes) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 16 | Read data, valid with ready |
| mem_ready_i | input | 1 | Memory access complete |
| rf_we_i | input | 1 | Register write enable |
| rf_wsel_i | input | 3 | Register write index |
| rf_wdata_i | input | 16 | Register write data |
| rf_sel_i | input | 3 | Register observe index |
| rf_rdata_o | output | 16 | Observed register value |

## Verification
The hardest cases involve register 7 named as the base of offset, postincrement or predecrement mode. In these cases the instruction pointer is both the base and the stream pointer, and the resolved address depends on which update is seen. The stimulus sweeps all 64 mode/register pairs in one run. Wait-state counts vary with each pair, so register 7 takes each of these roles while its value has been moved by earlier operations. Requests injected while busy, both start and register write, are issued at the first busy cycle of a long two-access resolution. This keeps them inside the window.

// File: rtl/opu_pkg.sv
package opu_pkg;
  typedef enum logic [2:0] {
    M_REG  = 3'd0,
    M_IND  = 3'd1,
    M_POST = 3'd2,
    M_PRE  = 3'd3,
    M_OFS  = 3'd4,
    M_IMM  = 3'd5,
    M_ABS  = 3'd6,
    M_RSV  = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_EXT  = 2'd1,
    S_OPND = 2'd2
  } state_e;
endpackage

// File: rtl/opu_regfile.sv
module opu_regfile #(
  parameter int DW = 16,
  parameter int NR = 8,
  localparam int SW = $clog2(NR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] wsel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [SW-1:0] sel_a_i,
  input  logic [SW-1:0] sel_b_i,
  input  logic [SW-1:0] sel_c_i,
  output logic [DW-1:0] rd_a_o,
  output logic [DW-1:0] rd_b_o,
  output logic [DW-1:0] rd_c_o,
  output logic [DW-1:0] rd_ip_o
);
  logic [DW-1:0] rf_q [NR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NR; i++) rf_q[i] <= '0;
    end else if (we_i) begin
      rf_q[wsel_i] <= wdata_i;
    end
  end

  assign rd_a_o  = rf_q[sel_a_i];
  assign rd_b_o  = rf_q[sel_b_i];
  assign rd_c_o  = rf_q[sel_c_i];
  assign rd_ip_o = rf_q[NR-1];
endmodule

// File: rtl/opu_seq.sv
module opu_seq
  import opu_pkg::*;
#(
  parameter int DW   = 16,
  parameter int STEP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [5:0]    spec_i,
  input  logic [DW-1:0] reg_a_i,
  input  logic [DW-1:0] reg_b_i,
  input  logic [DW-1:0] ip_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  output logic          done_o,
  output logic          is_reg_o,
  output logic [DW-1:0] operand_o,
  output logic [DW-1:0] ea_o,
  output logic [2:0]    sel_o,
  output logic [2:0]    mode_o,
  output logic          upd_en_o,
  output logic [2:0]    upd_sel_o,
  output logic [DW-1:0] upd_data_o
);
  localparam logic [DW-1:0] STEP_W = DW'(STEP);
  localparam logic [2:0]    IP_IDX = 3'd7;

  state_e        st_q;
  mode_e         mode_q;
  logic [2:0]    sel_q;
  logic [DW-1:0] ea_q, opnd_q, ea_out_q;
  logic          done_q, is_reg_q;
  logic [DW-1:0] base;
  logic          fin_opnd, fin_imm;

  assign busy_o     = (st_q != S_IDLE);
  assign mem_req_o  = busy_o;
  assign mem_addr_o = (st_q == S_EXT) ? ip_i : ea_q;
  // base of offset mode sees the already advanced pointer
  assign base       = (sel_q == IP_IDX) ? ip_i + STEP_W : reg_b_i;
  assign fin_opnd   = (st_q == S_OPND) && mem_ready_i;
  assign fin_imm    = (st_q == S_EXT) && mem_ready_i && (mode_q == M_IMM);

  always_comb begin
    upd_en_o   = 1'b0;
    upd_sel_o  = sel_q;
    upd_data_o = '0;
    if (fin_imm) begin
      upd_en_o   = 1'b1;
      upd_sel_o  = IP_IDX;
      upd_data_o = ip_i + STEP_W;
    end else if (fin_opnd) begin
      unique case (mode_q)
        M_POST: begin upd_en_o = 1'b1; upd_data_o = reg_b_i + STEP_W; end
        M_PRE:  begin upd_en_o = 1'b1; upd_data_o = ea_q; end
        M_OFS, M_ABS: begin
          upd_en_o   = 1'b1;
          upd_sel_o  = IP_IDX;
          upd_data_o = ip_i + STEP_W;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      mode_q   <= M_REG;
      sel_q    <= '0;
      ea_q     <= '0;
      opnd_q   <= '0;
      ea_out_q <= '0;
      done_q   <= 1'b0;
      is_reg_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          mode_q <= mode_e'(spec_i[5:3]);
          sel_q  <= spec_i[2:0];
          unique case (mode_e'(spec_i[5:3]))
            M_REG, M_RSV: begin
              opnd_q   <= reg_a_i;
              ea_out_q <= '0;
              is_reg_q <= 1'b1;
              done_q   <= 1'b1;
            end
            M_IND, M_POST: begin ea_q <= reg_a_i;          st_q <= S_OPND; end
            M_PRE:         begin ea_q <= reg_a_i - STEP_W; st_q <= S_OPND; end
            default:       st_q <= S_EXT;
          endcase
        end
        S_EXT: if (mem_ready_i) begin
          unique case (mode_q)
            M_IMM: begin
              opnd_q   <= mem_rdata_i;
              ea_out_q <= ip_i;
              is_reg_q <= 1'b0;
              done_q   <= 1'b1;
              st_q     <= S_IDLE;
            end
            M_ABS:   begin ea_q <= mem_rdata_i;        st_q <= S_OPND; end
            default: begin ea_q <= mem_rdata_i + base; st_q <= S_OPND; end
          endcase
        end
        S_OPND: if (mem_ready_i) begin
          opnd_q   <= mem_rdata_i;
          ea_out_q <= ea_q;
          is_reg_q <= 1'b0;
          done_q   <= 1'b1;
          st_q     <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign done_o    = done_q;
  assign is_reg_o  = is_reg_q;
  assign operand_o = opnd_q;
  assign ea_o      = ea_out_q;
  assign sel_o     = sel_q;
  assign mode_o    = mode_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)); // R9
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o); // R9
  AST_REG_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && spec_i[5:3] == 3'd0 |=> done_o && is_reg_o); // R2
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(mode_o) && $stable(sel_o)); // R10
endmodule

// File: rtl/opu_top.sv
module opu_top
  import opu_pkg::*;
#(
  parameter int DW   = 16,
  parameter int STEP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [5:0]    spec_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          is_reg_o,
  output logic [DW-1:0] operand_o,
  output logic [DW-1:0] ea_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  input  logic          rf_we_i,
  input  logic [2:0]    rf_wsel_i,
  input  logic [DW-1:0] rf_wdata_i,
  input  logic [2:0]    rf_sel_i,
  output logic [DW-1:0] rf_rdata_o
);
  localparam int            NREG   = 8;
  localparam logic [DW-1:0] STEP_W = DW'(STEP);

  logic [DW-1:0] rd_a, rd_b, rd_ip, upd_data, wdata;
  logic [2:0]    sel_q, mode_q, upd_sel, wsel;
  logic          upd_en, we;

  // unit side effects win; external writes only while idle
  assign we    = upd_en | (rf_we_i & ~busy_o);
  assign wsel  = upd_en ? upd_sel  : rf_wsel_i;
  assign wdata = upd_en ? upd_data : rf_wdata_i;

  opu_regfile #(.DW(DW), .NR(NREG)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .wsel_i  (wsel),
    .wdata_i (wdata),
    .sel_a_i (spec_i[2:0]),
    .sel_b_i (sel_q),
    .sel_c_i (rf_sel_i),
    .rd_a_o  (rd_a),
    .rd_b_o  (rd_b),
    .rd_c_o  (rf_rdata_o),
    .rd_ip_o (rd_ip)
  );

  opu_seq #(.DW(DW), .STEP(STEP)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .spec_i      (spec_i),
    .reg_a_i     (rd_a),
    .reg_b_i     (rd_b),
    .ip_i        (rd_ip),
    .mem_rdata_i (mem_rdata_i),
    .mem_ready_i (mem_ready_i),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .done_o      (done_o),
    .is_reg_o    (is_reg_o),
    .operand_o   (operand_o),
    .ea_o        (ea_o),
    .sel_o       (sel_q),
    .mode_o      (mode_q),
    .upd_en_o    (upd_en),
    .upd_sel_o   (upd_sel),
    .upd_data_o  (upd_data)
  );

  AST_POSTINC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && mode_q == M_POST |-> rd_b == ea_o + STEP_W); // R4
  AST_PREDEC_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && mode_q == M_PRE |-> rd_b == ea_o); // R5
  AST_IMM_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && mode_q == M_IMM |-> rd_ip == ea_o + STEP_W); // R7
endmodule

// File: tb/opu_top_tb_top.sv
module opu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  spec = '0;
  logic        busy, done, is_reg, mem_req;
  logic [15:0] operand, ea, mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic        rf_we = 1'b0;
  logic [2:0]  rf_wsel = '0;
  logic [15:0] rf_wdata = '0;
  logic [2:0]  rf_sel = '0;
  logic [15:0] rf_rdata;

  int checks = 0;
  int fails  = 0;
  int lat_g  = 0;
  int wait_cnt = 0;
  logic [15:0] m_rf [8];
  logic [15:0] addr_q [$];

  always #10 clk = ~clk;

  opu_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .spec_i(spec),
    .busy_o(busy), .done_o(done), .is_reg_o(is_reg), .operand_o(operand),
    .ea_o(ea), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
    .rf_we_i(rf_we), .rf_wsel_i(rf_wsel), .rf_wdata_i(rf_wdata),
    .rf_sel_i(rf_sel), .rf_rdata_o(rf_rdata)
  );

  function automatic logic [15:0] memf(logic [15:0] a);
    return (a ^ 16'h5a3c) + {a[7:0], a[15:8]};
  endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // memory responder, compared against expected address stream each clock (R9)
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (wait_cnt >= lat_g) begin
        mem_ready <= 1'b1;
        mem_rdata <= memf(mem_addr);
        if (addr_q.size() == 0) chk(1'b0, "R9 unexpected access", mem_addr, 16'h0);
        else begin
          logic [15:0] ex;
          ex = addr_q.pop_front();
          chk(mem_addr == ex, "R9 access address", mem_addr, ex);
        end
        wait_cnt = 0;
      end else begin
        mem_ready <= 1'b0;
        wait_cnt++;
      end
    end else begin
      mem_ready <= 1'b0;
      wait_cnt = 0;
    end
  end

  task automatic check_regs(string tag);
    for (int i = 0; i < 8; i++) begin
      rf_sel = 3'(i);
      #1;
      chk(rf_rdata == m_rf[i], tag, rf_rdata, m_rf[i]);
    end
  endtask

  task automatic write_reg(int idx, logic [15:0] v);
    @(negedge clk);
    rf_we = 1'b1; rf_wsel = 3'(idx); rf_wdata = v;
    @(negedge clk);
    rf_we = 1'b0;
    m_rf[idx] = v;
  endtask

  task automatic run_op(logic [5:0] sp, int lat, bit inj_s, bit inj_w);
    int m, r, nacc, k;
    logic [15:0] pc, ev, ee, ext;
    bit er;
    m = int'(sp[5:3]); r = int'(sp[2:0]);
    pc = m_rf[7]; er = 1'b0; ee = 16'h0; nacc = 0;
    case (m)
      1: begin ee = m_rf[r]; ev = memf(ee); addr_q.push_back(ee); nacc = 1; end
      2: begin ee = m_rf[r]; ev = memf(ee); addr_q.push_back(ee); nacc = 1;
               m_rf[r] = m_rf[r] + 16'd2; end
      3: begin m_rf[r] = m_rf[r] - 16'd2; ee = m_rf[r]; ev = memf(ee);
               addr_q.push_back(ee); nacc = 1; end
      4: begin ext = memf(pc); addr_q.push_back(pc); m_rf[7] = pc + 16'd2;
               ee = ext + m_rf[r]; ev = memf(ee); addr_q.push_back(ee); nacc = 2; end
      5: begin ev = memf(pc); ee = pc; addr_q.push_back(pc); m_rf[7] = pc + 16'd2;
               nacc = 1; end
      6: begin ee = memf(pc); addr_q.push_back(pc); ev = memf(ee);
               addr_q.push_back(ee); m_rf[7] = pc + 16'd2; nacc = 2; end
      default: begin ev = m_rf[r]; ee = 16'h0; er = 1'b1; end
    endcase
    lat_g = lat;
    @(negedge clk);
    start = 1'b1; spec = sp;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      start = 1'b0; rf_we = 1'b0;
      if (k == 1 && nacc > 0) begin
        if (inj_s) begin start = 1'b1; spec = 6'o03; end  // R10
        if (inj_w) begin rf_we = 1'b1; rf_wsel = 3'd2; rf_wdata = 16'hdead; end  // R11
      end
    end while (!done && k < 300);
    start = 1'b0; rf_we = 1'b0;
    if (er) chk(k == 1, "R2 done latency", 16'(k), 16'd1);
    else    chk(k == 1 + nacc * (lat + 1), "R9 done latency", 16'(k), 16'(1 + nacc * (lat + 1)));
    chk(operand == ev, $sformatf("R12 mode%0d r%0d operand", m, r), operand, ev);
    chk(ea == ee, $sformatf("R12 mode%0d r%0d ea", m, r), ea, ee);
    chk(is_reg == er, $sformatf("R2 mode%0d is_reg", m), 16'(is_reg), 16'(er));
    chk(addr_q.size() == 0, "R9 missing access", 16'(addr_q.size()), 16'h0);
    addr_q.delete();
    check_regs($sformatf("R12 mode%0d r%0d regs", m, r));
    if (inj_s) begin
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R10 stray start", {14'h0, busy, done}, 16'h0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_rf[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy", 16'(busy), 16'h0);
    chk(done == 1'b0, "R1 done", 16'(done), 16'h0);
    chk(mem_req == 1'b0, "R1 req", 16'(mem_req), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("R1 regs");

    // R11 idle writes
    for (int i = 0; i < 7; i++) write_reg(i, 16'h0100 * 16'(i + 1) + 16'(i * 6));
    write_reg(7, 16'h1000);
    check_regs("R11 idle write");

    // R3 R4 R5 R6 R7 R8 basic per mode
    run_op(6'o12, 0, 0, 0);  // R3
    run_op(6'o23, 1, 0, 0);  // R4
    run_op(6'o34, 2, 0, 0);  // R5
    run_op(6'o41, 1, 0, 0);  // R6
    run_op(6'o57, 0, 0, 0);  // R7
    run_op(6'o60, 2, 0, 0);  // R8
    run_op(6'o75, 0, 0, 0);  // R2 reserved mode

    // R12 full sweep
    for (int md = 0; md < 8; md++)
      for (int rg = 0; rg < 8; rg++)
        run_op(6'((md << 3) | rg), (md + rg) % 4, 0, 0);

    // R10 R11 injections while busy
    run_op(6'o61, 3, 1, 0);  // R10
    run_op(6'o45, 3, 0, 1);  // R11
    run_op(6'o27, 2, 1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule